// File: doc/BRIEF.md
# Embedded-Clock Frame Serializer

This block turns a stream of 10-bit parallel words (8 data bits plus 2 control bits) into a single serial bit stream that carries its own timing. Each word goes out as a 12-bit frame. A leading one and a trailing zero wrap the word, so the line falls at least once in every frame. A receiver can use that edge to recover the word boundary.

The block runs from a bit clock at twelve times the word rate. The word clock is an ordinary input, sampled in the bit-clock domain. A select input picks which word-clock edge captures the parallel word into a holding register. A frame is loaded from the holding register only at a frame boundary. A sync request replaces the data frames with a fixed training frame of six ones and six zeros, so a receiver can lock after power-up. A powerdown input stops the serializer and floats the line. An output-enable input floats the line without stopping the serializer. The float condition leaves the block as a separate enable bit beside the serial data bit.

Top module: `frame_serializer`

## Requirements
- R1: While rstN is low, serOut and serOe are both 0, and the holding register is cleared to zero.
- R2: Frames run back to back. Each frame is a one, then wordIn bits 0 to 9 (LSB first), then a zero. The first frame starts on the first bit-clock rising edge at which rstN and powerDown are both sampled inactive, and that frame is visible from the following bit period.
- R3: With edgeSel=1, wordIn is captured on a rising transition of wordClk. With edgeSel=0, it is captured on a falling transition. Both transitions are detected on bit-clock samples. The other transition captures nothing.
- R4: A word captured while a frame is being sent does not change that frame. The word goes out in the next frame.
- R5: If syncReq is 1 at a frame boundary, that frame is the training pattern: six ones followed by six zeros. The pattern repeats for as long as syncReq stays high, and data frames resume once it is low.
- R6: While powerDown is 1, serOut and serOe are 0 from the next bit period on, and wordClk transitions capture nothing. The held word survives and is the first frame sent after release.
- R7: serOe equals outEnable AND NOT powerDown as sampled at the previous bit-clock edge. outEnable does not affect serOut.
- R8: A run of equal serOut values never reaches 12 bit periods while running, so every frame contains a falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Bit clock, twelve times the word rate |
| rstN | input | 1 | Active-low synchronous reset |
| wordClk | input | 1 | Word clock, sampled by bitClk |
| edgeSel | input | 1 | 1: capture on rising wordClk, 0: on falling |
| wordIn | input | 10 | Parallel word: 8 data bits and 2 control bits |
| syncReq | input | 1 | Send the training pattern instead of data |
| powerDown | input | 1 | Stop serializing and float the line |
| outEnable | input | 1 | Line drive enable |
| serOut | output | 1 | Serial data bit |
| serOe | output | 1 | Line driver enable (0 means high impedance) |

## Verification
Three rules are checked by the assertions on every cycle. The line is quiet during reset and powerdown. The driver enable follows its inputs with one cycle of delay. No run of equal line values lasts a whole frame. Only the directed scenarios show how a frame is built: the bit order, which word-clock edge captures, that a capture in mid-frame waits for the boundary, the exact training pattern, and that the held word survives powerdown. Each scenario decodes frames at the serial pin and compares them with frames built from the requirements.

// File: rtl/ser_pkg.sv
package ser_pkg;
  // Strobes from the sequencing control to the datapath.
  typedef struct packed {
    logic capture;   // latch the parallel word into the holding register
    logic load;      // start a new frame this edge
    logic loadSync;  // the new frame is the training pattern
    logic idle;      // powered down: clear the shifter, drop drive
  } serStrobe_t;
endpackage

// File: rtl/ser_ctrl.sv
module ser_ctrl
  import ser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic       bitClk,
  input  logic       rstN,
  input  logic       wordClk,
  input  logic       edgeSel,
  input  logic       syncReq,
  input  logic       powerDown,
  output serStrobe_t strobe
);
  localparam int FRAME_W = WORD_W + 2;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_W - 1);

  logic             wordClkQ;
  logic [CNT_W-1:0] bitPos;
  logic             edgeSeen;
  logic             atBoundary;

  always_ff @(posedge bitClk) begin
    if (!rstN) wordClkQ <= 1'b0;
    else       wordClkQ <= wordClk;
  end

  // The position rests on the last bit so the first running edge loads a frame.
  always_ff @(posedge bitClk) begin
    if (!rstN || powerDown)   bitPos <= LAST_POS;
    else if (bitPos == LAST_POS) bitPos <= '0;
    else                      bitPos <= bitPos + 1'b1;
  end

  always_comb begin
    edgeSeen   = edgeSel ? (wordClk && !wordClkQ) : (!wordClk && wordClkQ);
    atBoundary = (bitPos == LAST_POS);
    strobe.idle     = powerDown;
    strobe.capture  = edgeSeen && !powerDown;
    strobe.load     = atBoundary && !powerDown;
    strobe.loadSync = atBoundary && !powerDown && syncReq;
  end
endmodule

// File: rtl/ser_datapath.sv
module ser_datapath
  import ser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  serStrobe_t        strobe,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              outEnable,
  output logic              serOut,
  output logic              serOe
);
  localparam int FRAME_W = WORD_W + 2;
  localparam int HALF_W  = FRAME_W / 2;
  localparam logic [FRAME_W-1:0] SYNC_FRAME =
    {{(FRAME_W - HALF_W){1'b0}}, {HALF_W{1'b1}}};

  logic [WORD_W-1:0]  holdReg;
  logic [FRAME_W-1:0] shiftReg;
  logic               oeReg;

  always_ff @(posedge bitClk) begin
    if (!rstN)              holdReg <= '0;
    else if (strobe.capture) holdReg <= wordIn;
  end

  // Bit 0 of the shifter is on the line; the frame shifts toward it.
  always_ff @(posedge bitClk) begin
    if (!rstN || strobe.idle) shiftReg <= '0;
    else if (strobe.loadSync) shiftReg <= SYNC_FRAME;
    else if (strobe.load)     shiftReg <= {1'b0, holdReg, 1'b1};
    else                      shiftReg <= shiftReg >> 1;
  end

  always_ff @(posedge bitClk) begin
    if (!rstN) oeReg <= 1'b0;
    else       oeReg <= outEnable && !strobe.idle;
  end

  assign serOut = shiftReg[0];
  assign serOe  = oeReg;
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
  import ser_pkg::*;
#(
  parameter int WORD_W = 10
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  logic              wordClk,
  input  logic              edgeSel,
  input  logic [WORD_W-1:0] wordIn,
  input  logic              syncReq,
  input  logic              powerDown,
  input  logic              outEnable,
  output logic              serOut,
  output logic              serOe
);
  serStrobe_t strobe;

  ser_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .bitClk   (bitClk),
    .rstN     (rstN),
    .wordClk  (wordClk),
    .edgeSel  (edgeSel),
    .syncReq  (syncReq),
    .powerDown(powerDown),
    .strobe   (strobe)
  );

  ser_datapath #(.WORD_W(WORD_W)) u_dp (
    .bitClk   (bitClk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wordIn   (wordIn),
    .outEnable(outEnable),
    .serOut   (serOut),
    .serOe    (serOe)
  );
endmodule

// File: rtl/ser_checker.sv
module ser_checker #(
  parameter int WORD_W = 10
) (
  input logic bitClk,
  input logic rstN,
  input logic powerDown,
  input logic outEnable,
  input logic serOut,
  input logic serOe
);
  localparam int FRAME_W = WORD_W + 2;

  logic       prevOut;
  logic [7:0] runLen;

  always_ff @(posedge bitClk) begin
    prevOut <= serOut;
    if (!rstN || powerDown)   runLen <= '0;
    else if (serOut != prevOut) runLen <= '0;
    else if (runLen != 8'hFF) runLen <= runLen + 1'b1;
  end

  assert_reset_quiet_R1: assert property (@(posedge bitClk)
    !rstN |=> (!serOut && !serOe));

  assert_pd_quiet_R6: assert property (@(posedge bitClk) disable iff (!rstN)
    powerDown |=> (!serOut && !serOe));

  assert_oe_follow_R7: assert property (@(posedge bitClk) disable iff (!rstN)
    1'b1 |=> (serOe == $past(outEnable && !powerDown)));

  assert_run_limit_R8: assert property (@(posedge bitClk) disable iff (!rstN || powerDown)
    runLen < 8'(FRAME_W - 1));
endmodule

bind frame_serializer ser_checker #(.WORD_W(WORD_W)) u_ser_checker (
  .bitClk   (bitClk),
  .rstN     (rstN),
  .powerDown(powerDown),
  .outEnable(outEnable),
  .serOut   (serOut),
  .serOe    (serOe)
);

// File: tb/test_frame_serializer.sv
`timescale 1ns/1ps
module test_frame_serializer;
  localparam int WORD_W  = 10;
  localparam int FRAME_W = WORD_W + 2;

  logic              bitClk = 1'b0;
  logic              rstN = 1'b0;
  logic              wordClk = 1'b0;
  logic              edgeSel = 1'b1;
  logic [WORD_W-1:0] wordIn = '0;
  logic              syncReq = 1'b0;
  logic              powerDown = 1'b0;
  logic              outEnable = 1'b0;
  logic              serOut;
  logic              serOe;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int runEdges = 0;

  always #2.5 bitClk = ~bitClk;

  frame_serializer #(.WORD_W(WORD_W)) i_frame_serializer (
    .bitClk(bitClk), .rstN(rstN), .wordClk(wordClk), .edgeSel(edgeSel),
    .wordIn(wordIn), .syncReq(syncReq), .powerDown(powerDown),
    .outEnable(outEnable), .serOut(serOut), .serOe(serOe)
  );

  // Counts running edges since the last reset or powerdown release.
  always @(posedge bitClk) begin
    if (!rstN || powerDown) runEdges <= 0;
    else                    runEdges <= runEdges + 1;
  end

  function automatic logic [FRAME_W-1:0] dataFrame(input logic [WORD_W-1:0] w);
    return {1'b0, w, 1'b1};
  endfunction

  localparam logic [FRAME_W-1:0] SYNC_EXP = 12'h03F;

  task automatic tick(input int n = 1);
    repeat (n) @(negedge bitClk);
  endtask

  task automatic checkEq(input string req, input logic [FRAME_W-1:0] act,
                         input logic [FRAME_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitFrameStart();
    while (runEdges % FRAME_W != 1) tick();
  endtask

  task automatic readFrame(output logic [FRAME_W-1:0] f);
    waitFrameStart();
    for (int i = 0; i < FRAME_W; i++) begin
      f[i] = serOut;
      tick();
    end
  endtask

  task automatic captureWord(input logic [WORD_W-1:0] w);
    wordIn = w;
    tick(2);
    wordClk = 1'b1;
    tick(3);
    wordClk = 1'b0;
    tick(3);
  endtask

  task automatic testReset();
    logic [FRAME_W-1:0] f;
    tick(4);
    checkEq("R1 serOut in reset", FRAME_W'(serOut), '0);
    checkEq("R1 serOe in reset", FRAME_W'(serOe), '0);
    outEnable = 1'b1;
    rstN = 1'b1;
    readFrame(f);
    checkEq("R2 first frame after reset", f, dataFrame('0));
    checkEq("R7 serOe after enable", FRAME_W'(serOe), 1);
  endtask

  task automatic testFrames();
    logic [FRAME_W-1:0] f;
    logic [WORD_W-1:0] pats [3] = '{10'h2A5, 10'h3FF, 10'h000};
    edgeSel = 1'b1;
    foreach (pats[i]) begin
      captureWord(pats[i]);
      readFrame(f);
      readFrame(f);
      checkEq("R2 frame layout", f, dataFrame(pats[i]));
      checkEq("R8 start one, stop zero", FRAME_W'({f[0], f[FRAME_W-1]}), 2'b10);
    end
  endtask

  task automatic testEdgeSel();
    logic [FRAME_W-1:0] f;
    edgeSel = 1'b0;
    wordIn = 10'h155; tick(2); wordClk = 1'b1; tick(2);
    wordIn = 10'h0C3; tick(1); wordClk = 1'b0; tick(2);
    wordIn = 10'h111;
    readFrame(f); readFrame(f);
    checkEq("R3 falling-edge capture", f, dataFrame(10'h0C3));
    edgeSel = 1'b1;
    wordIn = 10'h2D2; tick(2); wordClk = 1'b1; tick(2);
    wordIn = 10'h04F; tick(1); wordClk = 1'b0; tick(2);
    readFrame(f); readFrame(f);
    checkEq("R3 rising-edge capture", f, dataFrame(10'h2D2));
  endtask

  task automatic testMidFrame();
    logic [FRAME_W-1:0] f1, f2;
    edgeSel = 1'b1;
    captureWord(10'h0F0);
    readFrame(f1);
    waitFrameStart();
    fork
      readFrame(f1);
      begin
        tick(4);
        wordIn = 10'h30C;
        wordClk = 1'b1;
        tick(2);
        wordClk = 1'b0;
      end
    join
    readFrame(f2);
    checkEq("R4 frame in progress unchanged", f1, dataFrame(10'h0F0));
    checkEq("R4 new word in next frame", f2, dataFrame(10'h30C));
  endtask

  task automatic testSync();
    logic [FRAME_W-1:0] f;
    captureWord(10'h1A6);
    syncReq = 1'b1;
    readFrame(f);
    readFrame(f);
    checkEq("R5 training frame", f, SYNC_EXP);
    readFrame(f);
    checkEq("R5 training repeats", f, SYNC_EXP);
    syncReq = 1'b0;
    readFrame(f);
    readFrame(f);
    checkEq("R5 data resumes", f, dataFrame(10'h1A6));
  endtask

  task automatic testPowerDown();
    logic [FRAME_W-1:0] f;
    captureWord(10'h2E1);
    powerDown = 1'b1;
    tick(2);
    checkEq("R6 serOut quiet", FRAME_W'(serOut), '0);
    checkEq("R6 serOe low", FRAME_W'(serOe), '0);
    edgeSel = 1'b1;
    captureWord(10'h01E);
    edgeSel = 1'b0;
    captureWord(10'h01E);
    edgeSel = 1'b1;
    checkEq("R6 still quiet", FRAME_W'({serOut, serOe}), '0);
    powerDown = 1'b0;
    readFrame(f);
    checkEq("R6 held word first after release", f, dataFrame(10'h2E1));
  endtask

  task automatic testOutEnable();
    logic [FRAME_W-1:0] f;
    captureWord(10'h2B4);
    outEnable = 1'b0;
    tick(1);
    checkEq("R7 serOe drops", FRAME_W'(serOe), '0);
    readFrame(f);
    checkEq("R7 data unaffected by enable", f, dataFrame(10'h2B4));
    outEnable = 1'b1;
    tick(1);
    checkEq("R7 serOe returns", FRAME_W'(serOe), 1);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    testReset();
    testFrames();
    testEdgeSel();
    testMidFrame();
    testSync();
    testPowerDown();
    testOutEnable();
    finish();
  end

  initial begin
    repeat (100000) @(posedge bitClk);
    total++;
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end
endmodule